// File: doc/BRIEF.md
# Bridge Secondary Status and Control Registers

This block holds two 16-bit registers of a type-1 (bridge) configuration header: the secondary-side status word and the bridge control word. A configuration agent writes them through a port that carries the data, a starting byte lane and a byte count. It reads them back through a registered read port. Logic on the secondary bus raises single-cycle event pulses that latch error flags in the status word and the discard-timeout flag in the control word.

The status word is a set of sticky error flags that software clears by writing ones. Its capability bits and device-select timing field are fixed by parameters. The control word is mostly ordinary read/write enables. It also holds one sticky discard-timeout flag, and only a write of two or more bytes can clear that flag. The control word and the secondary bus reset bit leave the block straight from flops.

Top module: `brg_sec_regs`

## Requirements
- R1: On a clock edge with `rst` high, the status flags load `STAT_POR & 16'hF900` and the control word loads `CTRL_POR & 16'h0FFF`.
- R2: A status read returns the sticky flags in bits 8, 11, 12, 13, 14 and 15. Bit 5 returns `CAP_66MHZ` and bit 7 returns `CAP_FB2B`. Bits [10:9] return `DEVSEL_TIMING` (0 fast, 1 medium, 2 slow). All other bits read 0, and no write changes any of these non-flag bits.
- R3: A status write with `wr_off`=0 and `wr_cnt`=2 clears each flag whose data bit is 1. It leaves each flag whose data bit is 0 unchanged.
- R4: A status write with any other offset or count (`wr_off`=1, or `wr_cnt` other than 2) changes nothing.
- R5: `ev_stat[0]` sets status bit 8, and `ev_stat[1]` through `ev_stat[5]` set bits 11 through 15. Each flag is visible from the next cycle. If a flag is set and cleared in the same cycle, the set wins.
- R6: A control write updates control bits 0–7, 9 and 11 only in the byte lanes it covers. Lane i (bits 8i+7..8i) is covered when `wr_off` ≤ i < `wr_off`+`wr_cnt`.
- R7: Control bits 15:12 always read 0. Bit 8 always reads `CTRL_POR[8]`. No write changes either.
- R8: Control bit 10 (discard timeout flag) becomes 1 only in the cycle after `ev_discard` is high. Writing 1 to it never sets it.
- R9: Control bit 10 clears only when it is 1, the control write has data bit 10 = 1, and `wr_cnt` ≥ 2. If `ev_discard` is high in the same cycle, the flag stays 1.
- R10: With `rd_en` high, `rd_data` shows, from the next cycle on, the register selected by `rd_sel` (0 status, 1 control) as it was before that edge. `rd_data` holds its value while `rd_en` is low.
- R11: `ctrl_word` always equals the control register, and `sec_bus_rst` equals its bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 1 | Write target: 0 status, 1 control |
| wr_off | input | 1 | First byte lane of the write |
| wr_cnt | input | 3 | Number of bytes written |
| wr_data | input | 16 | Write data, aligned to register bit positions |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | Read target: 0 status, 1 control |
| rd_data | output | 16 | Registered read data |
| ev_stat | input | 6 | Error event pulses for status bits 8, 11..15 |
| ev_discard | input | 1 | Discard timeout event pulse |
| ctrl_word | output | 16 | Current control register |
| sec_bus_rst | output | 1 | Secondary bus reset control |

## Verification
The bench goes after the discard flag rule in each of its forms. A one-byte write with bit 10 set, an upper-lane-only write, and a two-byte write with a 0 in bit 10 must all leave the flag set; a design that cleared on any write, or ignored the byte count, would drop it early. It also writes ones into the flag while it is clear, which a design treating bit 10 as plain read/write would latch. A clear and a set in the same cycle, on both registers, shows whether a design lets the clear win. Partial status writes and writes of ones into read-only positions check that the fixed capability fields and lanes outside the write never move, and a long run of random traffic compares every cycle against the model.

// File: rtl/brg_sec_pkg.sv
package brg_sec_pkg;
  localparam int REG_W   = 16;
  localparam int LANES   = REG_W / 8;
  localparam int N_EV    = 6;

  // status word: sticky flags that software clears by writing ones
  localparam logic [REG_W-1:0] STAT_W1C_MASK = 16'hF900;
  localparam int STAT_CAP66_BIT  = 5;
  localparam int STAT_FB2B_BIT   = 7;
  localparam int STAT_DEVSEL_LSB = 9;

  // control word
  localparam logic [REG_W-1:0] CTRL_IMPL_MASK = 16'h0FFF;
  localparam logic [REG_W-1:0] CTRL_RW_MASK   = 16'h0AFF;
  localparam int CTRL_SBR_BIT = 6;
  localparam int CTRL_DT_BIT  = 10;

  typedef enum logic [1:0] {
    DEVSEL_FAST   = 2'd0,
    DEVSEL_MEDIUM = 2'd1,
    DEVSEL_SLOW   = 2'd2
  } devsel_e;

  // event index -> status bit position
  function automatic int ev_pos(input int idx);
    return (idx == 0) ? 8 : (10 + idx);
  endfunction

  function automatic logic [REG_W-1:0] ev_expand(input logic [N_EV-1:0] ev);
    logic [REG_W-1:0] v;
    v = '0;
    for (int i = 0; i < N_EV; i++) v[ev_pos(i)] = ev[i];
    return v;
  endfunction
endpackage

// File: rtl/brg_lane_dec.sv
module brg_lane_dec #(
  parameter int LANES = 2,
  parameter int CNT_W = 3
) (
  input  logic             off,
  input  logic [CNT_W-1:0] cnt,
  output logic [LANES-1:0] lane_en,
  output logic             full_word,
  output logic             multi_byte
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_en[i] = (i >= int'(off)) && (i < int'(off) + int'(cnt));
  end
  assign full_word  = !off && (int'(cnt) == LANES);
  assign multi_byte = int'(cnt) > 1;
endmodule

// File: rtl/brg_sec_status.sv
module brg_sec_status
  import brg_sec_pkg::*;
#(
  parameter logic [REG_W-1:0] STAT_POR      = '0,
  parameter bit               CAP_66MHZ     = 1'b0,
  parameter bit               CAP_FB2B      = 1'b0,
  parameter logic [1:0]       DEVSEL_TIMING = DEVSEL_FAST
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_go,
  input  logic             full_word,
  input  logic [REG_W-1:0] wr_data,
  input  logic [N_EV-1:0]  ev_stat,
  output logic [REG_W-1:0] stat_view
);
  localparam logic [REG_W-1:0] CAPS =
      (REG_W'(CAP_66MHZ) << STAT_CAP66_BIT) |
      (REG_W'(CAP_FB2B)  << STAT_FB2B_BIT)  |
      (REG_W'(DEVSEL_TIMING) << STAT_DEVSEL_LSB);

  logic [REG_W-1:0] flags_q;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] set_vec;

  always_comb begin
    clr_vec = (wr_go && full_word) ? (wr_data & STAT_W1C_MASK) : '0;
    set_vec = ev_expand(ev_stat);
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= STAT_POR & STAT_W1C_MASK;
    else     flags_q <= ((flags_q & ~clr_vec) | set_vec) & STAT_W1C_MASK;
  end

  assign stat_view = flags_q | CAPS;
endmodule

// File: rtl/brg_bridge_ctrl.sv
module brg_bridge_ctrl
  import brg_sec_pkg::*;
#(
  parameter logic [REG_W-1:0] CTRL_POR = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_go,
  input  logic [LANES-1:0] lane_en,
  input  logic             multi_byte,
  input  logic [REG_W-1:0] wr_data,
  input  logic             ev_discard,
  output logic [REG_W-1:0] ctrl_q
);
  logic [REG_W-1:0] wmask;
  logic [REG_W-1:0] nxt;
  logic             dt_clr;

  for (genvar l = 0; l < LANES; l++) begin : g_wm
    assign wmask[8*l +: 8] = (wr_go && lane_en[l]) ? CTRL_RW_MASK[8*l +: 8] : 8'h00;
  end

  always_comb begin
    dt_clr = wr_go && multi_byte && wr_data[CTRL_DT_BIT] && ctrl_q[CTRL_DT_BIT];
    nxt    = (ctrl_q & ~wmask) | (wr_data & wmask);
    if (ev_discard)  nxt[CTRL_DT_BIT] = 1'b1;
    else if (dt_clr) nxt[CTRL_DT_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= CTRL_POR & CTRL_IMPL_MASK;
    else     ctrl_q <= nxt & CTRL_IMPL_MASK;
  end
endmodule

// File: rtl/brg_rd_port.sv
module brg_rd_port #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_en,
  input  logic         rd_sel,
  input  logic [W-1:0] stat_view,
  input  logic [W-1:0] ctrl_view,
  output logic [W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_sel ? ctrl_view : stat_view;
  end
endmodule

// File: rtl/brg_sec_regs.sv
module brg_sec_regs
  import brg_sec_pkg::*;
#(
  parameter logic [15:0] STAT_POR      = 16'h0000,
  parameter logic [15:0] CTRL_POR      = 16'h0000,
  parameter bit          CAP_66MHZ     = 1'b0,
  parameter bit          CAP_FB2B      = 1'b0,
  parameter logic [1:0]  DEVSEL_TIMING = 2'd0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic        wr_off,
  input  logic [2:0]  wr_cnt,
  input  logic [15:0] wr_data,
  input  logic        rd_en,
  input  logic        rd_sel,
  output logic [15:0] rd_data,
  input  logic [5:0]  ev_stat,
  input  logic        ev_discard,
  output logic [15:0] ctrl_word,
  output logic        sec_bus_rst
);
  logic [LANES-1:0] lane_en;
  logic             full_word;
  logic             multi_byte;
  logic [REG_W-1:0] stat_view;
  logic [REG_W-1:0] ctrl_q;

  brg_lane_dec #(.LANES(LANES), .CNT_W(3)) u_dec (
    .off(wr_off), .cnt(wr_cnt), .lane_en(lane_en),
    .full_word(full_word), .multi_byte(multi_byte)
  );

  brg_sec_status #(
    .STAT_POR(STAT_POR), .CAP_66MHZ(CAP_66MHZ),
    .CAP_FB2B(CAP_FB2B), .DEVSEL_TIMING(DEVSEL_TIMING)
  ) u_stat (
    .clk(clk), .rst(rst), .wr_go(wr_en && !wr_sel), .full_word(full_word),
    .wr_data(wr_data), .ev_stat(ev_stat), .stat_view(stat_view)
  );

  brg_bridge_ctrl #(.CTRL_POR(CTRL_POR)) u_ctrl (
    .clk(clk), .rst(rst), .wr_go(wr_en && wr_sel), .lane_en(lane_en),
    .multi_byte(multi_byte), .wr_data(wr_data), .ev_discard(ev_discard),
    .ctrl_q(ctrl_q)
  );

  brg_rd_port #(.W(REG_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_sel(rd_sel),
    .stat_view(stat_view), .ctrl_view(ctrl_q), .rd_data(rd_data)
  );

  assign ctrl_word   = ctrl_q;
  assign sec_bus_rst = ctrl_q[CTRL_SBR_BIT];
endmodule

// File: rtl/brg_sec_regs_chk.sv
module brg_sec_regs_chk
  import brg_sec_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic        wr_sel,
  input logic        wr_off,
  input logic [2:0]  wr_cnt,
  input logic [15:0] wr_data,
  input logic [5:0]  ev_stat,
  input logic        ev_discard,
  input logic [15:0] ctrl_word,
  input logic [15:0] stat_view
);
  logic stat_full_wr;
  logic stat_part_wr;
  assign stat_full_wr = wr_en && !wr_sel && !wr_off && (wr_cnt == 3'd2);
  assign stat_part_wr = wr_en && !wr_sel && !(!wr_off && (wr_cnt == 3'd2));

  // R3
  p_w1c_clear_r3: assert property (@(posedge clk) disable iff (rst)
    stat_full_wr |=> ((stat_view & $past(wr_data & STAT_W1C_MASK & ~ev_expand(ev_stat))) == 16'h0));

  // R4
  p_partial_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    (stat_part_wr && (ev_stat == '0)) |=> $stable(stat_view));

  // R5
  p_event_sets_r5: assert property (@(posedge clk) disable iff (rst)
    (|ev_stat) |=> ((stat_view & $past(ev_expand(ev_stat))) == $past(ev_expand(ev_stat))));

  // R8
  p_dt_no_self_set_r8: assert property (@(posedge clk) disable iff (rst)
    (!ev_discard && !ctrl_word[CTRL_DT_BIT]) |=> !ctrl_word[CTRL_DT_BIT]);

  // R9
  p_dt_narrow_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (ctrl_word[CTRL_DT_BIT] && !(wr_en && wr_sel && (wr_cnt >= 3'd2))) |=> ctrl_word[CTRL_DT_BIT]);
endmodule

bind brg_sec_regs brg_sec_regs_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_off(wr_off),
  .wr_cnt(wr_cnt), .wr_data(wr_data), .ev_stat(ev_stat),
  .ev_discard(ev_discard), .ctrl_word(ctrl_word), .stat_view(stat_view)
);

// File: tb/brg_sec_regs_tb_top.sv
module brg_sec_regs_tb_top;
  localparam logic [15:0] T_STAT_POR = 16'h8000;
  localparam logic [15:0] T_CTRL_POR = 16'h0100;
  localparam bit          T_CAP66    = 1'b1;
  localparam bit          T_FB2B     = 1'b0;
  localparam logic [1:0]  T_DEVSEL   = 2'd2;

  logic clk = 1'b0;
  logic rst;
  logic wr_en, wr_sel, wr_off, rd_en, rd_sel, ev_discard;
  logic [2:0]  wr_cnt;
  logic [15:0] wr_data;
  logic [5:0]  ev_stat;
  logic [15:0] rd_data, ctrl_word;
  logic        sec_bus_rst;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // behavioural model state
  logic [15:0] m_stat, m_ctrl, m_rd;

  always #4 clk = ~clk;

  brg_sec_regs #(
    .STAT_POR(T_STAT_POR), .CTRL_POR(T_CTRL_POR), .CAP_66MHZ(T_CAP66),
    .CAP_FB2B(T_FB2B), .DEVSEL_TIMING(T_DEVSEL)
  ) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_off(wr_off),
    .wr_cnt(wr_cnt), .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_data(rd_data), .ev_stat(ev_stat), .ev_discard(ev_discard),
    .ctrl_word(ctrl_word), .sec_bus_rst(sec_bus_rst)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] stat_seen();
    logic [15:0] v;
    v = m_stat;
    v[5] = T_CAP66;
    v[7] = T_FB2B;
    v[10:9] = T_DEVSEL;
    return v;
  endfunction

  function automatic bit is_flag(input int b);
    return (b == 8) || (b >= 11);
  endfunction

  function automatic bit ctrl_rw(input int b);
    return (b <= 7) || (b == 9) || (b == 11);
  endfunction

  function automatic int flag_pos(input int i);
    if (i == 0) return 8;
    return 10 + i;
  endfunction

  task automatic model_edge();
    logic [15:0] ns, nc;
    bit full;
    if (rd_en) m_rd = rd_sel ? m_ctrl : stat_seen();
    ns = m_stat;
    full = (wr_off == 1'b0) && (wr_cnt == 3'd2);
    if (wr_en && !wr_sel && full)
      for (int b = 0; b < 16; b++) if (is_flag(b) && wr_data[b]) ns[b] = 1'b0;
    for (int i = 0; i < 6; i++) if (ev_stat[i]) ns[flag_pos(i)] = 1'b1;
    nc = m_ctrl;
    if (wr_en && wr_sel) begin
      for (int b = 0; b < 16; b++) begin
        int lane;
        lane = b / 8;
        if (ctrl_rw(b) && lane >= int'(wr_off) && lane < int'(wr_off) + int'(wr_cnt))
          nc[b] = wr_data[b];
      end
      if (m_ctrl[10] && wr_data[10] && wr_cnt >= 3'd2) nc[10] = 1'b0;
    end
    if (ev_discard) nc[10] = 1'b1;
    m_stat = ns;
    m_ctrl = nc;
  endtask

  task automatic step(input logic we, input logic ws, input logic off, input logic [2:0] cnt,
                      input logic [15:0] d, input logic re, input logic rs,
                      input logic [5:0] ev, input logic dis, input string tag);
    wr_en = we; wr_sel = ws; wr_off = off; wr_cnt = cnt; wr_data = d;
    rd_en = re; rd_sel = rs; ev_stat = ev; ev_discard = dis;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    wr_en = 0; rd_en = 0; ev_stat = '0; ev_discard = 0;
    chk({tag, " ctrl_word"}, ctrl_word, m_ctrl);
    chk("R11 sec_bus_rst", {15'h0, sec_bus_rst}, {15'h0, m_ctrl[6]});
    if (re) chk({tag, " R10 rd_data"}, rd_data, m_rd);
  endtask

  task automatic rd(input logic rs, input string tag);
    step(0, 0, 0, 3'd0, 16'h0, 1, rs, 6'h0, 0, tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (R10 all): actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1; wr_en = 0; wr_sel = 0; wr_off = 0; wr_cnt = 0; wr_data = 0;
    rd_en = 0; rd_sel = 0; ev_stat = 0; ev_discard = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    m_stat = T_STAT_POR & 16'hF900;
    m_ctrl = T_CTRL_POR & 16'h0FFF;
    m_rd   = 16'h0;
    chk("R1 reset ctrl", ctrl_word, 16'h0100);
    chk("R1 reset rd_data", rd_data, 16'h0000);
    rd(0, "R1 R2 reset status");            // expects 0x8420
    rd(1, "R1 reset control");
    step(0, 0, 0, 0, 0, 0, 0, 6'h3F, 0, "R5 all events");
    rd(0, "R5 flags set");
    step(1, 0, 0, 3'd2, 16'h2900, 0, 0, 0, 0, "R3 clear 8,11,13");
    rd(0, "R3 after clear");
    step(1, 0, 0, 3'd2, 16'h06A0, 0, 0, 0, 0, "R2 write ro bits");
    rd(0, "R2 ro bits unchanged");
    step(1, 0, 0, 3'd1, 16'hFFFF, 0, 0, 0, 0, "R4 one byte");
    step(1, 0, 1, 3'd2, 16'hFFFF, 0, 0, 0, 0, "R4 offset 1");
    step(1, 0, 0, 3'd4, 16'hFFFF, 0, 0, 0, 0, "R4 four bytes");
    rd(0, "R4 status unchanged");
    step(1, 0, 0, 3'd2, 16'h8000, 0, 0, 6'h20, 0, "R5 set beats clear");
    rd(0, "R5 bit15 kept");
    step(1, 0, 0, 3'd2, 16'hFFFF, 0, 0, 0, 0, "R3 clear all");
    rd(0, "R3 all clear");
    step(1, 1, 0, 3'd2, 16'hFFFF, 0, 0, 0, 0, "R6 R7 R8 full write ones");
    step(1, 1, 0, 3'd2, 16'h0400, 0, 0, 0, 0, "R8 write 1 to bit10");
    step(1, 1, 0, 3'd1, 16'h0000, 0, 0, 0, 0, "R6 low lane only");
    step(1, 1, 1, 3'd1, 16'h0000, 0, 0, 0, 0, "R6 high lane only");
    step(1, 1, 1, 3'd1, 16'hFFFF, 0, 0, 0, 0, "R6 R7 high lane ones");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R8 discard event");
    step(1, 1, 0, 3'd1, 16'h0400, 0, 0, 0, 0, "R9 one byte keeps");
    step(1, 1, 1, 3'd1, 16'h0400, 0, 0, 0, 0, "R9 high lane keeps");
    step(1, 1, 0, 3'd2, 16'h0000, 0, 0, 0, 0, "R9 zero keeps");
    step(1, 1, 0, 3'd2, 16'h0400, 0, 0, 0, 0, "R9 wide clear");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R8 set again");
    step(1, 1, 0, 3'd2, 16'h0400, 0, 0, 0, 1, "R9 set beats clear");
    step(1, 1, 0, 3'd2, 16'h0040, 1, 1, 0, 0, "R11 R10 reset bit, read old");
    rd(1, "R10 control now");
    for (int n = 0; n < 400; n++) begin
      logic [5:0] ev;
      ev = ($urandom % 4 == 0) ? 6'($urandom) : 6'h0;
      step(1'($urandom), 1'($urandom), 1'($urandom), 3'($urandom % 5), 16'($urandom),
           1'($urandom), 1'($urandom), ev, ($urandom % 6 == 0), "R3 R5 R6 R9 random");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule